// File: doc/BRIEF.md
# Ethernet Receive Frame Packer

This block sits behind a byte-stream receive MAC and turns every incoming Ethernet frame into a self-describing record inside one byte-wide receive FIFO. A frame is announced by a start pulse that carries its length. The block then admits the frame, or rejects it outright, and writes the record one byte per cycle. A record holds a fixed marker word, a header word with the stored length and an OK status, the payload zero-padded to the 60-byte Ethernet minimum, a CRC-32 over the padded payload, and zero fill up to a word boundary.

The host reads records back as 32-bit words through a single data-register port. The block follows the host's position inside the current record, using the length in the header to find the last word. It keeps a count of complete stored frames, which is decremented as each frame is fully read. A completed record sets a pending flag that drives the interrupt request line. Writing zero to the frame-count register flushes the FIFO.

The FIFO depth (`DEPTH`, a power of two in bytes) must be at least 1536 so that a maximum 1522-byte frame always fits. A flush also returns the packer to idle, and any remaining bytes of a frame in progress are then ignored.

Top module: `rx_frame_packer`

## Requirements
- R1: A frame shorter than 60 bytes is stored followed by zero bytes up to 60 bytes. The CRC is computed over the padded bytes.
- R2: The CRC is CRC-32 using the reflected polynomial 0xEDB88320, processed LSB first, with an initial value of 0xFFFFFFFF and no final inversion. It is stored as one word directly after the padded payload.
- R3: Each record is laid out as follows. Word 0 is the marker 0x5AA50143. Word 1 is the header, with the padded length plus 4 in bits 15:0 and status 0x0001 in bits 31:16. Next come the padded payload and the CRC. Zero bytes follow to bring the total to a multiple of 4. Bytes within every word are least significant first.
- R4: A frame is stored only when `rx_en` is high at its start pulse and the FIFO free space is at least the record size, round4(8 + padded + 4). Otherwise none of its bytes are stored, and its bytes are still consumed.
- R5: `frame_cnt` increments in the same cycle that `sof_ready` returns high after a stored record.
- R6: `host_rdata` holds the popped word one cycle after a `host_rd` pulse. After the last word of a record is popped, `frame_cnt` is one lower in the following cycle.
- R7: A `host_rd` pulse while `frame_cnt` is 0 yields a data word of 0 and does not pop the FIFO.
- R8: A count-register write of 0 empties the FIFO and zeroes the frame count. A write of any non-zero value has no effect.
- R9: `rx_irq` goes high when a record completes. It stays high until a `pend_clr` pulse arrives.
- R10: `host_rd` may be held high on consecutive cycles. The data is then returned in order, one word per cycle.
- R11: A start pulse is taken only while `sof_ready` is high. A payload byte is taken only while `byte_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receive enable, sampled at frame start |
| sof_valid | input | 1 | Frame start pulse |
| sof_len | input | LENW | Frame length in bytes, valid with `sof_valid` |
| sof_ready | output | 1 | Packer idle, start accepted |
| byte_valid | input | 1 | Payload byte valid |
| byte_data | input | 8 | Payload byte |
| byte_ready | output | 1 | Payload byte accepted this cycle |
| host_rd | input | 1 | Host read of the data register |
| host_rdata | output | 32 | Data word returned for the last read |
| cnt_wr | input | 1 | Host write to the frame-count register |
| cnt_wdata | input | 32 | Value written to the frame-count register |
| frame_cnt | output | log2(DEPTH)+1 | Complete frames held in the FIFO |
| pend_clr | input | 1 | Clears the receive pending flag |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
Record completion and its effects share one clock edge: `frame_cnt`, `rx_irq` and `sof_ready` all change on the edge that writes the final record byte. The bench therefore samples all three at the first falling edge where `sof_ready` is high again. A read word appears one edge after `host_rd` is sampled, so each word is taken at the next falling edge. The same applies to the decrement after a record's final word, which is checked at that edge. Inputs are driven only on falling edges, and `byte_ready` is read there, so each accepted byte is exactly the one present at the following rising edge.

// File: rtl/rxp_pkg.sv
package rxp_pkg;
  localparam logic [31:0] REC_MARKER  = 32'h5AA5_0143;
  localparam logic [15:0] REC_OK      = 16'h0001;
  localparam int          MIN_PAYLOAD = 60;
  localparam logic [31:0] CRC_POLY    = 32'hEDB8_8320;

  typedef enum logic [2:0] {
    W_IDLE, W_HDR, W_PAY, W_PAD, W_CRC, W_FILL, W_DROP
  } wr_state_t;

  typedef enum logic [1:0] {P_MARK, P_HDR, P_DATA} rd_phase_t;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'd0, b};
    for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    return r;
  endfunction
endpackage

// File: rtl/rxp_lane_ram.sv
module rxp_lane_ram #(
  parameter int WORDS = 512,
  parameter int LW    = 9
) (
  input  logic          clk,
  input  logic          we,
  input  logic [LW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic          re,
  input  logic [LW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/rxp_writer.sv
module rxp_writer
  import rxp_pkg::*;
#(
  parameter int LENW = 11,
  parameter int PW   = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            flush,
  input  logic            rx_en,
  input  logic            sof_valid,
  input  logic [LENW-1:0] sof_len,
  input  logic [PW-1:0]   free_bytes,
  input  logic            byte_valid,
  input  logic [7:0]      byte_data,
  output logic            sof_ready,
  output logic            byte_ready,
  output logic            wr_en,
  output logic [7:0]      wr_data,
  output logic            rec_done
);
  wr_state_t       st;
  logic [LENW-1:0] len_q, pad_q, idx;
  logic [2:0]      sub;
  logic [31:0]     crc_q;
  logic [LENW-1:0] padded_in;
  logic [LENW+1:0] rec_sz;
  logic            admit, last_fill;
  logic [31:0]     hdr_word, sel_word;

  assign padded_in = (sof_len < LENW'(MIN_PAYLOAD)) ? LENW'(MIN_PAYLOAD) : sof_len;
  assign rec_sz    = ({2'b00, padded_in} + (LENW+2)'(15)) & ~(LENW+2)'(3);
  assign admit     = rx_en && (32'(free_bytes) >= 32'(rec_sz));
  assign hdr_word  = {REC_OK, 16'(pad_q) + 16'd4};
  assign sel_word  = sub[2] ? hdr_word : REC_MARKER;
  assign last_fill = (sub[1:0] == (2'd3 - pad_q[1:0]));

  assign sof_ready  = (st == W_IDLE);
  assign byte_ready = (st == W_PAY) || (st == W_DROP);

  always_comb begin
    wr_en    = 1'b0;
    wr_data  = 8'd0;
    rec_done = 1'b0;
    unique case (st)
      W_HDR:  begin wr_en = 1'b1; wr_data = 8'(sel_word >> {sub[1:0], 3'b000}); end
      W_PAY:  begin wr_en = byte_valid; wr_data = byte_data; end
      W_PAD:  wr_en = 1'b1;
      W_CRC:  begin
        wr_en    = 1'b1;
        wr_data  = 8'(crc_q >> {sub[1:0], 3'b000});
        rec_done = (sub == 3'd3) && (pad_q[1:0] == 2'd0);
      end
      W_FILL: begin wr_en = 1'b1; rec_done = last_fill; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      st    <= W_IDLE;
      len_q <= '0;
      pad_q <= '0;
      idx   <= '0;
      sub   <= '0;
      crc_q <= '1;
    end else begin
      unique case (st)
        W_IDLE: if (sof_valid) begin
          len_q <= sof_len;
          pad_q <= padded_in;
          idx   <= '0;
          sub   <= '0;
          crc_q <= '1;
          if (admit)              st <= W_HDR;
          else if (sof_len != '0) st <= W_DROP;
        end
        W_HDR: begin
          sub <= sub + 3'd1;
          if (sub == 3'd7) st <= (len_q == '0) ? W_PAD : W_PAY;
        end
        W_PAY: if (byte_valid) begin
          crc_q <= crc_step(crc_q, byte_data);
          idx   <= idx + LENW'(1);
          if (idx == len_q - LENW'(1))
            st <= (len_q < LENW'(MIN_PAYLOAD)) ? W_PAD : W_CRC;
        end
        W_PAD: begin
          crc_q <= crc_step(crc_q, 8'd0);
          idx   <= idx + LENW'(1);
          if (idx == LENW'(MIN_PAYLOAD - 1)) st <= W_CRC;
        end
        W_CRC: begin
          sub <= sub + 3'd1;
          if (sub == 3'd3) begin
            sub <= '0;
            st  <= (pad_q[1:0] == 2'd0) ? W_IDLE : W_FILL;
          end
        end
        W_FILL: begin
          sub <= sub + 3'd1;
          if (last_fill) st <= W_IDLE;
        end
        W_DROP: if (byte_valid) begin
          idx <= idx + LENW'(1);
          if (idx == len_q - LENW'(1)) st <= W_IDLE;
        end
        default: st <= W_IDLE;
      endcase
    end
  end

  // R11: one beat of an accepted frame start leaves the idle state
  a_r11_start_leaves_idle: assert property (@(posedge clk) disable iff (rst)
    (sof_ready && sof_valid && !flush && (sof_len != '0 || admit)) |=> !sof_ready);

  // R1: padding always brings the byte index to the minimum before the CRC
  a_r1_pad_reaches_min: assert property (@(posedge clk) disable iff (rst)
    (st == W_CRC) |-> (idx >= LENW'(MIN_PAYLOAD)));
endmodule

// File: rtl/rxp_reader.sv
module rxp_reader
  import rxp_pkg::*;
#(
  parameter int PW = 12,
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          host_rd,
  input  logic          rec_done,
  input  logic [15:0]   hdr_len,
  output logic          rd_en,
  output logic [PW-1:0] rptr,
  output logic [CW-1:0] frame_cnt,
  output logic          zero_q
);
  rd_phase_t   phase;
  logic [15:0] remain, hdr_al, eff_remain;
  logic        hdr_ld, frame_end;

  assign rd_en      = host_rd && (frame_cnt != '0) && !flush;
  assign hdr_al     = {hdr_len[15:2], 2'b00} + ((hdr_len[1:0] != 2'b00) ? 16'd4 : 16'd0);
  assign eff_remain = hdr_ld ? hdr_al : remain;
  assign frame_end  = rd_en && (phase == P_DATA) && (eff_remain == 16'd4);

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      phase     <= P_MARK;
      remain    <= '0;
      hdr_ld    <= 1'b0;
      rptr      <= '0;
      frame_cnt <= '0;
      zero_q    <= 1'b1;
    end else begin
      hdr_ld    <= rd_en && (phase == P_HDR);
      frame_cnt <= frame_cnt + CW'(rec_done) - CW'(frame_end);
      if (host_rd) zero_q <= (frame_cnt == '0);
      if (hdr_ld) remain <= hdr_al;
      if (rd_en) begin
        rptr <= rptr + PW'(4);
        unique case (phase)
          P_MARK: phase <= P_HDR;
          P_HDR:  phase <= P_DATA;
          default: begin
            if (frame_end) begin
              phase  <= P_MARK;
              remain <= '0;
            end else begin
              remain <= eff_remain - 16'd4;
            end
          end
        endcase
      end
    end
  end

  // R5 / R6: the frame count moves by at most one per cycle unless flushed
  a_r5_cnt_step: assert property (@(posedge clk) disable iff (rst)
    !flush |=> (frame_cnt == $past(frame_cnt) || frame_cnt == $past(frame_cnt) + CW'(1)
               || frame_cnt == $past(frame_cnt) - CW'(1)));

  // R7: a read with no stored frame leaves the read pointer alone
  a_r7_empty_no_pop: assert property (@(posedge clk) disable iff (rst)
    (host_rd && frame_cnt == '0 && !flush) |=> $stable(rptr));

  // R6: between records the remaining count is empty
  a_r6_idle_remain: assert property (@(posedge clk) disable iff (rst)
    (phase == P_MARK) |-> (remain == 16'd0));
endmodule

// File: rtl/rx_frame_packer.sv
module rx_frame_packer #(
  parameter int DEPTH = 2048,
  parameter int LENW  = 11,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1,
  localparam int CW   = AW + 1,
  localparam int LW   = AW - 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rx_en,
  input  logic            sof_valid,
  input  logic [LENW-1:0] sof_len,
  output logic            sof_ready,
  input  logic            byte_valid,
  input  logic [7:0]      byte_data,
  output logic            byte_ready,
  input  logic            host_rd,
  output logic [31:0]     host_rdata,
  input  logic            cnt_wr,
  input  logic [31:0]     cnt_wdata,
  output logic [CW-1:0]   frame_cnt,
  input  logic            pend_clr,
  output logic            rx_irq
);
  logic          flush, wr_en, rec_done, rd_en, zero_q, pending;
  logic [7:0]    wr_data;
  logic [PW-1:0] wptr, rptr, used_b, free_b;
  logic [31:0]   q_word;

  assign flush  = cnt_wr && (cnt_wdata == 32'd0);
  assign used_b = wptr - rptr;
  assign free_b = PW'(DEPTH) - used_b;

  always_ff @(posedge clk) begin
    if (rst || flush) wptr <= '0;
    else if (wr_en)   wptr <= wptr + PW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst)           pending <= 1'b0;
    else if (rec_done) pending <= 1'b1;
    else if (pend_clr) pending <= 1'b0;
  end
  assign rx_irq = pending;

  rxp_writer #(.LENW(LENW), .PW(PW)) u_writer (
    .clk, .rst, .flush, .rx_en, .sof_valid, .sof_len,
    .free_bytes(free_b), .byte_valid, .byte_data,
    .sof_ready, .byte_ready, .wr_en, .wr_data, .rec_done
  );

  rxp_reader #(.PW(PW), .CW(CW)) u_reader (
    .clk, .rst, .flush, .host_rd, .rec_done,
    .hdr_len(q_word[15:0]), .rd_en, .rptr, .frame_cnt, .zero_q
  );

  for (genvar g = 0; g < 4; g++) begin : g_lane
    rxp_lane_ram #(.WORDS(DEPTH / 4), .LW(LW)) u_ram (
      .clk,
      .we   (wr_en && (wptr[1:0] == 2'(g))),
      .waddr(wptr[AW-1:2]),
      .wdata(wr_data),
      .re   (rd_en),
      .raddr(rptr[AW-1:2]),
      .rdata(q_word[8*g +: 8])
    );
  end

  assign host_rdata = zero_q ? 32'd0 : q_word;

  // R4: stored bytes never exceed the FIFO depth
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
    used_b <= PW'(DEPTH));

  // R9: a completed record raises the interrupt request
  a_r9_irq_set: assert property (@(posedge clk) disable iff (rst)
    rec_done |=> rx_irq);
endmodule

// File: tb/tb_rx_frame_packer.sv
module tb_rx_frame_packer;
  localparam int DEPTH = 512;
  localparam int LENW  = 11;
  localparam int CW    = $clog2(DEPTH) + 1;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            rx_en = 1'b0, sof_valid = 1'b0, byte_valid = 1'b0;
  logic [LENW-1:0] sof_len = '0;
  logic [7:0]      byte_data = '0;
  logic            host_rd = 1'b0, cnt_wr = 1'b0, pend_clr = 1'b0;
  logic [31:0]     cnt_wdata = '0;
  logic            sof_ready, byte_ready, rx_irq;
  logic [31:0]     host_rdata;
  logic [CW-1:0]   frame_cnt;

  rx_frame_packer #(.DEPTH(DEPTH), .LENW(LENW)) dut (.*);

  always #10 clk = ~clk;

  int n_tests = 0, n_fail = 0;
  int model_used = 0, exp_cnt = 0;
  logic [31:0] exp_q[$];
  int          fr_words[$];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(int seed, int i);
    return 8'(seed * 29 + i * 7 + (i >> 3));
  endfunction

  // Builds the expected record (R1, R2, R3) and the admission decision (R4)
  task automatic model_frame(int len, int seed);
    int padded, total, nw;
    logic [31:0] c;
    logic [7:0] b[$];
    padded = (len < 60) ? 60 : len;
    total  = ((8 + padded + 4 + 3) / 4) * 4;
    if (!(rx_en && (DEPTH - model_used >= total))) return;
    for (int i = 0; i < padded; i++) b.push_back(i < len ? pat(seed, i) : 8'h00);
    c = 32'hFFFF_FFFF;
    foreach (b[i]) begin
      c = c ^ {24'd0, b[i]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
    end
    for (int k = 0; k < 4; k++) b.push_back(c[8*k +: 8]);
    while (b.size() % 4 != 0) b.push_back(8'h00);
    exp_q.push_back(32'h5AA5_0143);
    exp_q.push_back({16'h0001, 16'(padded + 4)});
    nw = 2;
    for (int i = 0; i < b.size(); i += 4) begin
      exp_q.push_back({b[i+3], b[i+2], b[i+1], b[i]});
      nw++;
    end
    fr_words.push_back(nw);
    model_used += total;
    exp_cnt++;
  endtask

  task automatic send(int len, int seed);
    int i;
    @(negedge clk);
    while (!sof_ready) @(negedge clk);
    model_frame(len, seed);
    sof_valid = 1'b1;
    sof_len   = LENW'(len);
    @(negedge clk);
    sof_valid = 1'b0;
    chk("R11 start taken", {31'd0, sof_ready}, (len == 0 && exp_q.size() == 0) ? 32'd1 : 32'd0);
    i = 0;
    while (i < len) begin
      if (byte_ready) begin
        byte_valid = 1'b1;
        byte_data  = pat(seed, i);
        i++;
      end else begin
        byte_valid = 1'b0;
      end
      @(negedge clk);
    end
    byte_valid = 1'b0;
    while (!sof_ready) @(negedge clk);
    chk("R5 count at record end", 32'(frame_cnt), 32'(exp_cnt));
  endtask

  // Reads one stored frame; burst=1 holds host_rd on consecutive cycles (R10)
  task automatic read_frame(bit burst);
    int nw;
    logic [31:0] e;
    nw = fr_words.pop_front();
    @(negedge clk);
    for (int w = 0; w < nw; w++) begin
      host_rd = 1'b1;
      @(negedge clk);
      if (!burst) begin
        host_rd = 1'b0;
        @(negedge clk);
      end
      e = exp_q.pop_front();
      model_used -= 4;
      if (w == nw - 1) begin
        host_rd = 1'b0;
        exp_cnt--;
      end
      chk(burst ? "R10 burst word" : "R6 word", host_rdata, e);
    end
    host_rd = 1'b0;
    chk("R6 count after last word", 32'(frame_cnt), 32'(exp_cnt));
  endtask

  task automatic read_empty();
    @(negedge clk);
    host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    chk("R7 empty read data", host_rdata, 32'd0);
    chk("R7 empty read count", 32'(frame_cnt), 32'd0);
  endtask

  task automatic cnt_write(logic [31:0] v);
    @(negedge clk);
    cnt_wr = 1'b1;
    cnt_wdata = v;
    @(negedge clk);
    cnt_wr = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R5 reset count", 32'(frame_cnt), 32'd0);
    chk("R9 reset irq", {31'd0, rx_irq}, 32'd0);
    chk("R11 reset start ready", {31'd0, sof_ready}, 32'd1);
    chk("R11 reset byte ready", {31'd0, byte_ready}, 32'd0);
    read_empty();

    // R4: disabled receive drops the frame whole
    send(20, 1);
    chk("R4 disabled drop", 32'(frame_cnt), 32'd0);
    chk("R9 no irq on drop", {31'd0, rx_irq}, 32'd0);
    rx_en = 1'b1;

    // R1 R2 R3: length sweep, alternating read styles
    for (int len = 0; len <= 70; len++) begin
      send(len, len + 3);
      read_frame(len[0]);
    end
    send(100, 7); read_frame(1'b1);
    send(257, 8); read_frame(1'b0);

    // R9: pending flag and its clear
    send(33, 9);
    chk("R9 irq set", {31'd0, rx_irq}, 32'd1);
    @(negedge clk); pend_clr = 1'b1; @(negedge clk); pend_clr = 1'b0;
    chk("R9 irq cleared", {31'd0, rx_irq}, 32'd0);
    read_frame(1'b0);
    chk("R9 irq stays clear", {31'd0, rx_irq}, 32'd0);

    // R4: fill to the exact boundary
    send(100, 11); send(100, 12); send(100, 13);
    send(165, 14);
    chk("R4 one word short rejected", 32'(frame_cnt), 32'd3);
    send(164, 15);
    chk("R4 exact fit accepted", 32'(frame_cnt), 32'd4);
    send(1, 16);
    chk("R4 full rejected", 32'(frame_cnt), 32'd4);
    read_frame(1'b1);
    send(100, 17);
    chk("R4 freed space reused", 32'(frame_cnt), 32'd4);
    for (int k = 0; k < 4; k++) read_frame(k[0]);
    read_empty();

    // R8: non-zero count write ignored, zero write flushes
    send(45, 21); send(61, 22);
    cnt_write(32'd5);
    chk("R8 nonzero write ignored", 32'(frame_cnt), 32'd2);
    read_frame(1'b0);
    cnt_write(32'd0);
    chk("R8 flush clears count", 32'(frame_cnt), 32'd0);
    exp_q.delete(); fr_words.delete(); model_used = 0; exp_cnt = 0;
    read_empty();
    send(62, 23);
    read_frame(1'b1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule